// File: doc/BRIEF.md
# Interrupt Event Controller

This block gathers a parameterised number of hardware interrupt lines and a matching set of software-pending bits, and hands them to one CPU through a single event register. Each line is serviced only when it is asserted by hardware or pending by software, is unmasked, and has been routed to the CPU through its target register. Reading the event register returns a typed word that names the next source to service. The same read masks that source, so software unmasks it again once the handler has run. Two inter-processor interrupt sources, "other" and "self", share the event register and are served ahead of hardware lines.

Software works on the pending and mask state only through paired set and clear banks. Writing a 1 acts on a bit, and writing a 0 leaves it alone, so no read-modify-write sequence is needed. A single IRQ output tells the CPU that the event register has something to return. The bus is a plain 32-bit register port. Read data is registered and shows on the output one cycle after the read strobe.

Top module: `aic_evt_ctrl`

## Requirements
- R1: After reset every line mask and both IPI masks are 1, every software-pending, IPI-pending and target bit is 0, `irq_out` is low and an event read returns 0.
- R2: A read of offset 0x0004 returns NUM_LINES in bits 15:0 and 0 in bits 27:24 (die count minus one), with all other bits 0. A read of offset 0x2000 returns 0.
- R3: Software-pending banks sit at 0x4000 (set) and 0x4080 (clear), and mask banks sit at 0x4100 (set) and 0x4180 (clear). Line n is bit n%32 of word base+(n/32)*4. A 1 sets or clears the bit and a 0 has no effect. A read of either address of a bank returns the current bits.
- R4: Line n is eligible when (input n OR software-pending n) AND NOT mask n AND target n. Target n is bit 0 of offset 0x3000+n*4, and writing 1 there routes the line to the CPU.
- R5: A read of offset 0x2004 with no unmasked pending IPI and some eligible line returns {8'd0, 8'd1, 16'd line}, where line is the lowest-numbered eligible line, and it sets that line's mask bit. With nothing to report the read returns 0.
- R6: Writes to 0x2008 set IPI-pending and writes to 0x200C clear it. 0x2024 sets the IPI mask and 0x2028 clears it. Bit 0 is the "other" IPI and bit 31 is the "self" IPI. An unmasked pending IPI wins over lines in an event read, which returns {8'd0, 8'd4, 16'd1} for other, served before self, or {8'd0, 8'd4, 16'd2} for self, and masks that IPI.
- R7: `irq_out` is high exactly when some line is eligible or some IPI is pending and unmasked.
- R8: Reads of unmapped offsets, including bank words past the last line, return 0. Writes to them change no state.
- R9: Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_lines | input | NUM_LINES | Hardware interrupt inputs, level sensitive |
| irq_out | output | 1 | Interrupt request to the CPU |

## Verification
A table drives the event read with hardware patterns: no line, a single low line, two lines in different words, only the top line, only the first line of the second word, and every line at once. Together they separate a correct lowest-first search from a highest-first search, from one that stops at word 0, and from one that indexes the wrong word. Directed sequences set a line through the software bank with the input low, hold an asserted line behind a mask and behind a missing route, and raise both IPIs together and alongside a hardware line. These show whether each gating term is present, whether the "other" IPI is served before "self", and whether IPIs win over lines. Zero writes and unmapped accesses are followed by read-back of the bank state they could have corrupted.

// File: rtl/aic_pkg.sv
package aic_pkg;

    localparam logic [15:0] OFF_INFO     = 16'h0004;
    localparam logic [15:0] OFF_CPU_ID   = 16'h2000;
    localparam logic [15:0] OFF_EVENT    = 16'h2004;
    localparam logic [15:0] OFF_IPI_SEND = 16'h2008;
    localparam logic [15:0] OFF_IPI_ACK  = 16'h200C;
    localparam logic [15:0] OFF_IPI_MSET = 16'h2024;
    localparam logic [15:0] OFF_IPI_MCLR = 16'h2028;

    // Bank selector is addr[15:7]; each bank spans 0x80 bytes.
    localparam logic [8:0] BANK_SW_SET = 9'h080;
    localparam logic [8:0] BANK_SW_CLR = 9'h081;
    localparam logic [8:0] BANK_MK_SET = 9'h082;
    localparam logic [8:0] BANK_MK_CLR = 9'h083;
    localparam logic [3:0] PAGE_TARGET = 4'h3;

    typedef enum logic [7:0] {
        EV_NONE = 8'd0,
        EV_HW   = 8'd1,
        EV_IPI  = 8'd4
    } ev_kind_e;

    typedef struct packed {
        logic [7:0]  die;
        ev_kind_e    kind;
        logic [15:0] num;
    } ev_word_t;

    localparam logic [15:0] IPI_NUM_OTHER = 16'd1;
    localparam logic [15:0] IPI_NUM_SELF  = 16'd2;

    function automatic ev_word_t make_event(ev_kind_e k, logic [15:0] n);
        ev_word_t e;
        e.die  = 8'd0;
        e.kind = k;
        e.num  = n;
        return e;
    endfunction

endpackage

// File: rtl/aic_w1_bank.sv
module aic_w1_bank #(
    parameter int    N       = 64,
    parameter bit    RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [4:0]   word_sel,
    input  logic [31:0]  wdata,
    input  logic [N-1:0] force_set,
    output logic [N-1:0] bits
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        localparam int W = i / 32;
        localparam int B = i % 32;
        logic hit;
        assign hit = (word_sel == 5'(W)) && wdata[B];
        always_ff @(posedge clk) begin
            if (rst)
                bits[i] <= RST_VAL;
            else if (force_set[i] || (set_en && hit))
                bits[i] <= 1'b1;
            else if (clr_en && hit)
                bits[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/aic_lowest.sv
module aic_lowest #(
    parameter int N  = 64,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/aic_ipi.sv
module aic_ipi (
    input  logic       clk,
    input  logic       rst,
    input  logic       send_en,
    input  logic       ack_en,
    input  logic       mset_en,
    input  logic       mclr_en,
    input  logic [1:0] sel,      // [0] other, [1] self
    input  logic [1:0] take,     // event read consumed this IPI
    output logic [1:0] pend,
    output logic [1:0] mask
);
    for (genvar k = 0; k < 2; k++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[k] <= 1'b0;
                mask[k] <= 1'b1;
            end else begin
                if (send_en && sel[k])
                    pend[k] <= 1'b1;
                else if (ack_en && sel[k])
                    pend[k] <= 1'b0;
                if (take[k] || (mset_en && sel[k]))
                    mask[k] <= 1'b1;
                else if (mclr_en && sel[k])
                    mask[k] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/aic_evt_ctrl.sv
module aic_evt_ctrl
    import aic_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [15:0]          bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] irq_lines,
    output logic                 irq_out
);
    localparam int NW = (NUM_LINES + 31) / 32;
    localparam int IW = $clog2(NUM_LINES);

    // ---------------- address decode ----------------
    logic       aligned, word_ok, tgt_ok;
    logic [8:0] bank;
    logic [4:0] word_sel;
    logic [9:0] tgt_line;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign bank     = bus_addr[15:7];
    assign word_sel = bus_addr[6:2];
    assign word_ok  = aligned && (int'(word_sel) < NW);
    assign tgt_line = bus_addr[11:2];
    assign tgt_ok   = aligned && (bus_addr[15:12] == PAGE_TARGET)
                      && (int'(tgt_line) < NUM_LINES);

    logic sw_set_we, sw_clr_we, mk_set_we, mk_clr_we, tgt_we;
    assign sw_set_we = bus_wr && word_ok && (bank == BANK_SW_SET);
    assign sw_clr_we = bus_wr && word_ok && (bank == BANK_SW_CLR);
    assign mk_set_we = bus_wr && word_ok && (bank == BANK_MK_SET);
    assign mk_clr_we = bus_wr && word_ok && (bank == BANK_MK_CLR);
    assign tgt_we    = bus_wr && tgt_ok;

    logic evt_rd;
    assign evt_rd = bus_rd && (bus_addr == OFF_EVENT);

    // ---------------- state ----------------
    logic [NUM_LINES-1:0] sw_bits, mask_bits, routed, mask_force, elig;
    logic [1:0]           ipi_pend, ipi_mask, ipi_avail, ipi_take;

    aic_w1_bank #(.N(NUM_LINES), .RST_VAL(1'b0)) u_sw (
        .clk(clk), .rst(rst), .set_en(sw_set_we), .clr_en(sw_clr_we),
        .word_sel(word_sel), .wdata(bus_wdata),
        .force_set('0), .bits(sw_bits)
    );

    aic_w1_bank #(.N(NUM_LINES), .RST_VAL(1'b1)) u_mask (
        .clk(clk), .rst(rst), .set_en(mk_set_we), .clr_en(mk_clr_we),
        .word_sel(word_sel), .wdata(bus_wdata),
        .force_set(mask_force), .bits(mask_bits)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_tgt
        always_ff @(posedge clk) begin
            if (rst)
                routed[i] <= 1'b0;
            else if (tgt_we && (tgt_line == 10'(i)))
                routed[i] <= bus_wdata[0];
        end
    end

    aic_ipi u_ipi (
        .clk(clk), .rst(rst),
        .send_en(bus_wr && (bus_addr == OFF_IPI_SEND)),
        .ack_en (bus_wr && (bus_addr == OFF_IPI_ACK)),
        .mset_en(bus_wr && (bus_addr == OFF_IPI_MSET)),
        .mclr_en(bus_wr && (bus_addr == OFF_IPI_MCLR)),
        .sel({bus_wdata[31], bus_wdata[0]}),
        .take(ipi_take),
        .pend(ipi_pend), .mask(ipi_mask)
    );

    // ---------------- event selection ----------------
    assign elig      = (irq_lines | sw_bits) & ~mask_bits & routed;
    assign ipi_avail = ipi_pend & ~ipi_mask;

    logic          line_found;
    logic [IW-1:0] line_idx;

    aic_lowest #(.N(NUM_LINES), .IW(IW)) u_pick (
        .req(elig), .found(line_found), .idx(line_idx)
    );

    ev_word_t ev;
    always_comb begin
        ev         = make_event(EV_NONE, 16'd0);
        ipi_take   = 2'b00;
        mask_force = '0;
        if (ipi_avail[0]) begin
            ev          = make_event(EV_IPI, IPI_NUM_OTHER);
            ipi_take[0] = evt_rd;
        end else if (ipi_avail[1]) begin
            ev          = make_event(EV_IPI, IPI_NUM_SELF);
            ipi_take[1] = evt_rd;
        end else if (line_found) begin
            ev = make_event(EV_HW, 16'(line_idx));
            if (evt_rd)
                mask_force = NUM_LINES'(1) << line_idx;
        end
    end

    assign irq_out = (|elig) || (|ipi_avail);

    // ---------------- read path ----------------
    function automatic logic [31:0] bank_word(input logic [NUM_LINES-1:0] v,
                                              input logic [4:0] w);
        logic [31:0] r;
        r = '0;
        for (int b = 0; b < 32; b++) begin
            if (int'(w) * 32 + b < NUM_LINES)
                r[b] = v[int'(w) * 32 + b];
        end
        return r;
    endfunction

    logic [31:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        if (bus_addr == OFF_INFO)
            rd_mux = {4'd0, 4'd0, 8'd0, 16'(NUM_LINES)};
        else if (bus_addr == OFF_CPU_ID)
            rd_mux = '0;
        else if (bus_addr == OFF_EVENT)
            rd_mux = ev;
        else if (bus_addr == OFF_IPI_SEND || bus_addr == OFF_IPI_ACK)
            rd_mux = {ipi_pend[1], 30'd0, ipi_pend[0]};
        else if (bus_addr == OFF_IPI_MSET || bus_addr == OFF_IPI_MCLR)
            rd_mux = {ipi_mask[1], 30'd0, ipi_mask[0]};
        else if (tgt_ok)
            rd_mux = {31'd0, routed[tgt_line[IW-1:0]]};
        else if (word_ok && (bank == BANK_SW_SET || bank == BANK_SW_CLR))
            rd_mux = bank_word(sw_bits, word_sel);
        else if (word_ok && (bank == BANK_MK_SET || bank == BANK_MK_CLR))
            rd_mux = bank_word(mask_bits, word_sel);
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end

endmodule

// File: rtl/aic_evt_ctrl_chk.sv
module aic_evt_ctrl_chk #(
    parameter int NUM_LINES = 64
) (
    input logic                 clk,
    input logic                 rst,
    input logic [15:0]          bus_addr,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic                 irq_out,
    input logic [NUM_LINES-1:0] mask_bits,
    input logic [NUM_LINES-1:0] elig,
    input logic [1:0]           ipi_avail
);
    localparam int IW = $clog2(NUM_LINES);

    logic ev_rd;
    assign ev_rd = bus_rd && (bus_addr == 16'h2004);

    // R5: hardware event type when only lines are eligible
    p_hw_event_type_r5: assert property (@(posedge clk) disable iff (rst)
        (ev_rd && ipi_avail == 2'b00 && elig != '0) |=> bus_rdata[23:16] == 8'd1);

    // R5: the served line is masked afterwards
    p_served_line_masked_r5: assert property (@(posedge clk) disable iff (rst)
        (ev_rd && ipi_avail == 2'b00 && elig != '0) |=> mask_bits[bus_rdata[IW-1:0]]);

    // R5: empty event when nothing is available
    p_empty_event_r5: assert property (@(posedge clk) disable iff (rst)
        (ev_rd && ipi_avail == 2'b00 && elig == '0) |=> bus_rdata == 32'd0);

    // R6: IPIs win over lines
    p_ipi_first_r6: assert property (@(posedge clk) disable iff (rst)
        (ev_rd && ipi_avail != 2'b00) |=> bus_rdata[23:16] == 8'd4);

    // R8: upper unmapped space reads zero
    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr[15:12] >= 4'h5) |=> bus_rdata == 32'd0);

    // R3: writing zeros to the mask-set bank changes nothing
    p_zero_write_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_rd && bus_addr[15:7] == 9'h082 && bus_wdata == 32'd0)
        |=> $stable(mask_bits));

    // R7: no request without a source
    p_irq_source_r7: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (elig != '0 || ipi_avail != 2'b00));

    // R9: read data holds between reads
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd && !$past(bus_rd)) |=> $stable(bus_rdata));

endmodule

bind aic_evt_ctrl aic_evt_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .mask_bits(mask_bits), .elig(elig),
    .ipi_avail(ipi_avail)
);

// File: tb/tb_aic_evt_ctrl.sv
module tb_aic_evt_ctrl;
    localparam int NL = 64;

    logic          clk = 1'b0;
    logic          rst;
    logic [15:0]   bus_addr;
    logic          bus_wr, bus_rd;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] irq_lines;
    logic          irq_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    aic_evt_ctrl #(.NUM_LINES(NL)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_lines(irq_lines), .irq_out(irq_out)
    );

    // hardware pattern, expected event word
    localparam logic [95:0] VEC [6] = '{
        {64'h0000_0000_0000_0000, 32'h0000_0000},
        {64'h0000_0000_0000_0020, 32'h0001_0005},
        {64'h0000_0100_0000_0080, 32'h0001_0007},
        {64'h8000_0000_0000_0000, 32'h0001_003F},
        {64'h0000_0001_0000_0000, 32'h0001_0020},
        {64'hFFFF_FFFF_FFFF_FFFF, 32'h0001_0000}
    };

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic unmask_all();
        wr(16'h4180, 32'hFFFF_FFFF);
        wr(16'h4184, 32'hFFFF_FFFF);
    endtask

    initial begin
        logic [31:0] d;
        rst = 1'b1; bus_addr = '0; bus_wr = 0; bus_rd = 0;
        bus_wdata = '0; irq_lines = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 irq_out", {31'd0, irq_out}, 32'd0);
        rd(16'h2004, d); check("R1 event", d, 32'd0);
        rd(16'h4100, d); check("R1 mask w0", d, 32'hFFFF_FFFF);
        rd(16'h4184, d); check("R1 mask w1", d, 32'hFFFF_FFFF);
        rd(16'h4000, d); check("R1 sw w0", d, 32'd0);
        rd(16'h2024, d); check("R1 ipi mask", d, 32'h8000_0001);

        // R2 info and cpu id; R9 timing via these reads
        rd(16'h0004, d); check("R2 info (R9)", d, 32'h0000_0040);
        rd(16'h2000, d); check("R2 cpu id", d, 32'd0);

        // R4 route gating
        unmask_all();
        irq_lines = 64'h8;
        @(negedge clk);
        check("R4 unrouted irq", {31'd0, irq_out}, 32'd0);
        rd(16'h2004, d); check("R4 unrouted event", d, 32'd0);
        for (int i = 0; i < NL; i++) wr(16'h3000 + 16'(i * 4), 32'd1);
        rd(16'h300C, d); check("R4 target readback", d, 32'd1);
        check("R7 routed irq", {31'd0, irq_out}, 32'd1);
        irq_lines = '0;

        // R5/R7 table walk
        foreach (VEC[v]) begin
            logic [63:0] hw;
            logic [31:0] ex;
            hw = VEC[v][95:32];
            ex = VEC[v][31:0];
            irq_lines = hw;
            @(negedge clk);
            check("R7 irq vs pattern", {31'd0, irq_out}, {31'd0, hw != 0});
            rd(16'h2004, d); check("R5 event", d, ex);
            if (ex[23:16] == 8'd1) begin
                rd(16'h4100 + 16'((ex[15:0] >> 5) * 4), d);
                check("R5 line masked", {31'd0, d[ex[4:0]]}, 32'd1);
            end
            unmask_all();
        end
        irq_lines = '0;

        // R3 set/clear banks
        wr(16'h4100, 32'd0);
        rd(16'h4100, d); check("R3 zero write ignored", d, 32'd0);
        wr(16'h4104, 32'h10);
        rd(16'h4104, d); check("R3 mask set line36", d, 32'h10);
        rd(16'h4184, d); check("R3 mask via clr addr", d, 32'h10);
        wr(16'h4184, 32'h10);
        rd(16'h4104, d); check("R3 mask clr", d, 32'd0);
        wr(16'h4004, 32'h2);
        rd(16'h4004, d); check("R3 sw set line33", d, 32'h2);
        rd(16'h2004, d); check("R4 sw line event", d, 32'h0001_0021);
        wr(16'h4084, 32'h2);
        rd(16'h4004, d); check("R3 sw clr", d, 32'd0);
        unmask_all();
        check("R3 cleared no irq", {31'd0, irq_out}, 32'd0);

        // R4 mask gating
        irq_lines = 64'h400;
        wr(16'h4100, 32'h400);
        check("R4 masked irq", {31'd0, irq_out}, 32'd0);
        rd(16'h2004, d); check("R4 masked event", d, 32'd0);
        wr(16'h4180, 32'h400);
        check("R7 unmasked irq", {31'd0, irq_out}, 32'd1);
        irq_lines = '0;

        // R6 IPIs
        wr(16'h2028, 32'h8000_0001);
        wr(16'h2008, 32'h8000_0001);
        check("R7 ipi irq", {31'd0, irq_out}, 32'd1);
        rd(16'h2004, d); check("R6 other first", d, 32'h0004_0001);
        rd(16'h2004, d); check("R6 self next", d, 32'h0004_0002);
        rd(16'h2004, d); check("R6 both masked", d, 32'd0);
        check("R6 masked irq low", {31'd0, irq_out}, 32'd0);
        rd(16'h2024, d); check("R6 ipi mask read", d, 32'h8000_0001);
        wr(16'h2028, 32'h8000_0001);
        check("R6 still pending", {31'd0, irq_out}, 32'd1);
        wr(16'h200C, 32'h8000_0001);
        check("R6 ack clears", {31'd0, irq_out}, 32'd0);
        irq_lines = 64'h4;
        wr(16'h2008, 32'h8000_0000);
        rd(16'h2004, d); check("R6 ipi beats line", d, 32'h0004_0002);
        rd(16'h2004, d); check("R5 line after ipi", d, 32'h0001_0002);
        wr(16'h200C, 32'h8000_0000);
        irq_lines = '0;
        unmask_all();

        // R8 unmapped space
        rd(16'h5000, d); check("R8 read 0x5000", d, 32'd0);
        rd(16'h0008, d); check("R8 read 0x0008", d, 32'd0);
        rd(16'h4108, d); check("R8 bank past end", d, 32'd0);
        wr(16'h4108, 32'hFFFF_FFFF);
        wr(16'h4500, 32'hFFFF_FFFF);
        wr(16'h0004, 32'hFFFF_FFFF);
        rd(16'h4100, d); check("R8 mask w0 intact", d, 32'd0);
        rd(16'h4104, d); check("R8 mask w1 intact", d, 32'd0);
        rd(16'h0004, d); check("R8 info intact", d, 32'h0000_0040);

        done = 1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 50000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule